// File: doc/BRIEF.md
# Digit-Serial Shared Constant Multiplier (59x and 89x)

This block multiplies one serial operand by two fixed constants, 59 and 89, at the same time. It uses only digit-serial adders, subtractors and delay flip-flops, with no multiplier. The operand `x` arrives `DIGIT_W` bits per clock, least significant digit first. The first digit of every word is flagged by `word_start`. Every cycle carries one digit, and there are no idle gaps inside a word. Both products leave on their own digit streams of the same width, one digit per cycle, one cycle after the matching input digit.

The two products share one intermediate term, fifteen times x. It is built as x delayed by four bit positions minus x. The fifteen-x stream runs through one two-bit delay chain. The far end of that chain gives 15x scaled by four, and 59x is that value minus x. The middle tap gives 15x scaled by two, and 89x is that value plus 59x. So the network has one adder, two subtractors and six delay bits in total, whatever the word length.

The word length is chosen by whoever drives the stream. For an n-bit operand, the source streams `ceil((n+7)/DIGIT_W)` digits. It extends the operand with its sign bit if it is two's complement, or with zeros if it is unsigned, so that the full result fits. The results are exact modulo 2 to the power of (digits streamed times `DIGIT_W`).

Top module: `shared_cmul_ds`

## Requirements
- R1: Over a word of N digits, the digits on `p59_dig`, reassembled least significant first, equal 59 times the reassembled input word, modulo 2^(N*DIGIT_W).
- R2: Over the same word, the digits on `p89_dig`, reassembled least significant first, equal 89 times the input word, modulo 2^(N*DIGIT_W).
- R3: The output digit for input digit j appears on the clock edge after digit j is presented. `out_start` is 1 exactly on the output digit that belongs to a flagged input digit, and 0 on every other output digit.
- R4: Words sent back to back, with no idle cycle between them, are each computed as if the block had just been reset. No carry and no delayed bit crosses a `word_start`.
- R5: Asserting `word_start` before the current word is complete abandons that word. The new word is computed correctly regardless of the partial word's contents.
- R6: A two's complement operand streamed with sign extension gives two's complement products. An unsigned operand streamed with zero extension gives unsigned products.
- R7: While `rst` is 1 at a clock edge, both product outputs and `out_start` are 0 after that edge.
- R8: The first output digit of a word equals the low `DIGIT_W` bits of the constant times the first input digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| word_start | input | 1 | Marks the least significant digit of a new word |
| x_dig | input | DIGIT_W | Operand digit, least significant digit first |
| out_start | output | 1 | Marks the first output digit of a word |
| p59_dig | output | DIGIT_W | Digit of 59 times x |
| p89_dig | output | DIGIT_W | Digit of 89 times x |

## Verification
A carry or delayed bit left over from the previous word shows up in the first output digit. That digit is on the ports one cycle after `word_start`. The first-digit check catches this as soon as the word begins, and the back-to-back and aborted-word sweeps make sure such leftover state is actually present. A wrong tap on the shared chain, or a swapped subtrahend, leaves the low digits correct but corrupts higher digits later in the word. Comparing every reassembled word, over all operand values of a 6-bit configuration in both signed and unsigned form, exposes these errors by the end of the word in which they occur.

// File: rtl/shared_cmul_pkg.sv
`timescale 1ns/1ps
package shared_cmul_pkg;

  // Operation selected for a serial arithmetic cell.
  typedef enum logic {
    ARITH_ADD = 1'b0,
    ARITH_SUB = 1'b1
  } arith_e;

  // Shift amounts of the decomposition:
  //   m15 = (x << SH_15) - x
  //   m59 = (m15 << SH_59) - x
  //   m89 = (m15 << SH_89) + m59
  localparam int unsigned SH_15 = 4;
  localparam int unsigned SH_59 = 2;
  localparam int unsigned SH_89 = 1;

endpackage

// File: rtl/dsm_shift.sv
`timescale 1ns/1ps
// Digit-serial left shift: holds the last DEPTH stream bits.
// Provides taps for shift amounts TAP_LO..DEPTH from one chain.
module dsm_shift #(
  parameter int unsigned DIGIT_W = 2,
  parameter int unsigned DEPTH   = 2,
  parameter int unsigned TAP_LO  = 1,
  localparam int unsigned NTAP   = DEPTH - TAP_LO + 1,
  localparam int unsigned CW     = DIGIT_W + DEPTH
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clr,
  input  logic [DIGIT_W-1:0]            din,
  output logic [NTAP-1:0][DIGIT_W-1:0]  tap
);

  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_eff;
  logic [CW-1:0]    window;

  // At a word start the bits below position zero are zero.
  assign hist_eff = clr ? '0 : hist_q;
  assign window   = {din, hist_eff};

  // Bit DEPTH of window is the current digit's LSB, so a shift by s
  // starts s bits below it.
  for (genvar gt = 0; gt < NTAP; gt++) begin : g_tap
    localparam int unsigned SH = TAP_LO + gt;
    assign tap[gt] = window[DEPTH-SH +: DIGIT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= window[CW-1 -: DEPTH];
  end

endmodule

// File: rtl/dsm_addsub.sv
`timescale 1ns/1ps
// Digit-serial adder or subtractor: ripple of DIGIT_W full adders with
// one carry flip-flop. Subtraction inverts b and injects a one at word start.
module dsm_addsub
  import shared_cmul_pkg::*;
#(
  parameter int unsigned DIGIT_W = 2,
  parameter arith_e      OP      = ARITH_ADD
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [DIGIT_W-1:0] a,
  input  logic [DIGIT_W-1:0] b,
  output logic [DIGIT_W-1:0] y
);

  localparam logic CIN_START = (OP == ARITH_SUB);

  logic [DIGIT_W-1:0] b_eff;
  logic [DIGIT_W:0]   cy;
  logic               carry_q;

  if (OP == ARITH_SUB) begin : g_sub
    assign b_eff = ~b;
  end else begin : g_add
    assign b_eff = b;
  end

  assign cy[0] = clr ? CIN_START : carry_q;

  for (genvar gb = 0; gb < DIGIT_W; gb++) begin : g_fa
    assign y[gb]    = a[gb] ^ b_eff[gb] ^ cy[gb];
    assign cy[gb+1] = (a[gb] & b_eff[gb]) | (cy[gb] & (a[gb] ^ b_eff[gb]));
  end

  always_ff @(posedge clk) begin
    if (rst) carry_q <= 1'b0;
    else     carry_q <= cy[DIGIT_W];
  end

endmodule

// File: rtl/shared_cmul_ds.sv
`timescale 1ns/1ps
// Digit-serial 59x / 89x network sharing the 15x partial product.
module shared_cmul_ds
  import shared_cmul_pkg::*;
#(
  parameter int unsigned DIGIT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_start,
  input  logic [DIGIT_W-1:0] x_dig,
  output logic               out_start,
  output logic [DIGIT_W-1:0] p59_dig,
  output logic [DIGIT_W-1:0] p89_dig
);

  logic [0:0][DIGIT_W-1:0]       x_sh;
  logic [DIGIT_W-1:0]            m15;
  logic [SH_59-1:0][DIGIT_W-1:0] m15_sh;
  logic [DIGIT_W-1:0]            m59;
  logic [DIGIT_W-1:0]            m89;

  // x << 4
  dsm_shift #(.DIGIT_W(DIGIT_W), .DEPTH(SH_15), .TAP_LO(SH_15)) u_sh_x (
    .clk(clk), .rst(rst), .clr(word_start), .din(x_dig), .tap(x_sh)
  );

  // 15x = (x << 4) - x
  dsm_addsub #(.DIGIT_W(DIGIT_W), .OP(ARITH_SUB)) u_sub15 (
    .clk(clk), .rst(rst), .clr(word_start), .a(x_sh[0]), .b(x_dig), .y(m15)
  );

  // One chain gives 15x << 1 (tap 0) and 15x << 2 (tap 1)
  dsm_shift #(.DIGIT_W(DIGIT_W), .DEPTH(SH_59), .TAP_LO(SH_89)) u_sh_15 (
    .clk(clk), .rst(rst), .clr(word_start), .din(m15), .tap(m15_sh)
  );

  // 59x = (15x << 2) - x
  dsm_addsub #(.DIGIT_W(DIGIT_W), .OP(ARITH_SUB)) u_sub59 (
    .clk(clk), .rst(rst), .clr(word_start),
    .a(m15_sh[SH_59-SH_89]), .b(x_dig), .y(m59)
  );

  // 89x = (15x << 1) + 59x
  dsm_addsub #(.DIGIT_W(DIGIT_W), .OP(ARITH_ADD)) u_add89 (
    .clk(clk), .rst(rst), .clr(word_start), .a(m15_sh[0]), .b(m59), .y(m89)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_start <= 1'b0;
      p59_dig   <= '0;
      p89_dig   <= '0;
    end else begin
      out_start <= word_start;
      p59_dig   <= m59;
      p89_dig   <= m89;
    end
  end

endmodule

// File: rtl/shared_cmul_ds_chk.sv
`timescale 1ns/1ps
module shared_cmul_ds_chk #(
  parameter int unsigned DIGIT_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               word_start,
  input logic [DIGIT_W-1:0] x_dig,
  input logic               out_start,
  input logic [DIGIT_W-1:0] p59_dig,
  input logic [DIGIT_W-1:0] p89_dig
);

  localparam int K59 = 59;
  localparam int K89 = 89;

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_reset_clear_R7: assert property (@(posedge clk)
    $past(rst) |-> (p59_dig == '0 && p89_dig == '0 && !out_start));

  assert_first_digit59_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(word_start)) |->
      p59_dig == DIGIT_W'(K59 * int'($past(x_dig))));

  assert_first_digit89_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(word_start)) |->
      p89_dig == DIGIT_W'(K89 * int'($past(x_dig))));

  assert_start_marks_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && word_start) |=> out_start);

  assert_no_stray_start_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && !word_start) |=> !out_start);

endmodule

bind shared_cmul_ds shared_cmul_ds_chk #(.DIGIT_W(DIGIT_W)) u_chk (
  .clk(clk), .rst(rst), .word_start(word_start), .x_dig(x_dig),
  .out_start(out_start), .p59_dig(p59_dig), .p89_dig(p89_dig)
);

// File: tb/sim_shared_cmul_ds.sv
`timescale 1ns/1ps
module sim_shared_cmul_ds;

  localparam int DW = 2;
  localparam int WW = 6;
  localparam int RW = WW + 7;
  localparam int ND = (RW + DW - 1) / DW;
  localparam int TB = ND * DW;
  localparam int MAXS = 1024;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          word_start = 1'b0;
  logic [DW-1:0] x_dig = '0;
  logic          out_start;
  logic [DW-1:0] p59_dig;
  logic [DW-1:0] p89_dig;

  always #2 clk = ~clk;

  shared_cmul_ds #(.DIGIT_W(DW)) u0 (
    .clk(clk), .rst(rst), .word_start(word_start), .x_dig(x_dig),
    .out_start(out_start), .p59_dig(p59_dig), .p89_dig(p89_dig)
  );

  int total = 0;
  int fails = 0;
  bit done  = 0;

  logic [DW-1:0] s_dig [MAXS];
  logic          s_st  [MAXS];
  logic [DW-1:0] c59   [MAXS];
  logic [DW-1:0] c89   [MAXS];
  logic          cst   [MAXS];
  int            slen;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [TB-1:0] v, input int ndig);
    for (int j = 0; j < ndig; j++) begin
      s_dig[slen] = v[j*DW +: DW];
      s_st[slen]  = (j == 0);
      slen++;
    end
  endtask

  task automatic play();
    for (int i = 0; i <= slen; i++) begin
      @(negedge clk);
      if (i > 0) begin
        c59[i-1] = p59_dig;
        c89[i-1] = p89_dig;
        cst[i-1] = out_start;
      end
      if (i < slen) begin
        word_start = s_st[i];
        x_dig      = s_dig[i];
      end else begin
        word_start = 1'b0;
        x_dig      = '0;
      end
    end
  endtask

  // Check one full word captured at stream position b for operand xv.
  task automatic check_word(input int b, input longint xv, input string tag);
    logic [TB-1:0] g59, g89, e59, e89;
    bit st_ok;
    e59 = TB'(59 * xv);
    e89 = TB'(89 * xv);
    st_ok = 1;
    for (int j = 0; j < ND; j++) begin
      g59[j*DW +: DW] = c59[b+j];
      g89[j*DW +: DW] = c89[b+j];
      if (cst[b+j] != (j == 0)) st_ok = 0;
    end
    check(g59 == e59, {"R1 ", tag}, longint'(g59), longint'(e59));
    check(g89 == e89, {"R2 ", tag}, longint'(g89), longint'(e89));
    check(st_ok, {"R3 out_start ", tag}, longint'(st_ok), 1);
    check(c59[b] == e59[DW-1:0] && c89[b] == e89[DW-1:0], {"R8 first digit ", tag},
          longint'({c59[b], c89[b]}), longint'({e59[DW-1:0], e89[DW-1:0]}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    // R7: reset holds outputs low even with active inputs.
    rst = 1'b1;
    word_start = 1'b1;
    x_dig = '1;
    repeat (3) @(negedge clk);
    check(p59_dig == '0 && p89_dig == '0 && !out_start, "R7 reset",
          longint'({out_start, p59_dig, p89_dig}), 0);
    rst = 1'b0;
    word_start = 1'b0;
    x_dig = '0;
    @(negedge clk);

    // R1 R2 R4 R6: every signed operand, back to back, sign-extended.
    slen = 0;
    for (int v = -(1 << (WW-1)); v < (1 << (WW-1)); v++) push_word(TB'(v), ND);
    play();
    for (int k = 0; k < (1 << WW); k++)
      check_word(k*ND, longint'(k - (1 << (WW-1))), "R4 R6 signed");

    // R1 R2 R4 R6: every unsigned operand, back to back, zero-extended.
    slen = 0;
    for (int v = 0; v < (1 << WW); v++) push_word(TB'(v), ND);
    play();
    for (int k = 0; k < (1 << WW); k++)
      check_word(k*ND, longint'(k), "R4 R6 unsigned");

    // R5: abandoned partial words followed by complete words.
    slen = 0;
    push_word(TB'(-1), 3);
    push_word(TB'(5), ND);
    push_word(TB'(-32), ND - 1);
    push_word(TB'(31), ND);
    push_word(TB'(-1), 1);
    push_word(TB'(-23), ND);
    play();
    check_word(3, 5, "R5 abort");
    check_word(3 + ND + ND - 1, 31, "R5 abort");
    check_word(3 + ND + ND - 1 + ND + 1, -23, "R5 abort");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule